// File: doc/BRIEF.md
# Configuration Address/Data Port Decoder

This block sits as a slave on a host bridge's I/O port bus. It implements the classic two-port scheme for reaching configuration space. A 32-bit address register selects a bus, a device/function and a register. A four-byte data window then carries reads and writes to the selected register. When the address register's enable bit is set, an access to the data window becomes a single configuration request on a simple downstream interface. That request carries the bus number, the device/function number, a 10-bit dword index covering 4 KB per function, lane byte enables and write data.

Software first writes a full dword to the address port. It then performs byte, word or dword accesses in the data window. The lanes touched follow from the low two port bits and the access size. Each I/O access is a one-cycle strobe and ends with a one-cycle completion pulse. If the downstream target never acknowledges, a bounded timer ends the request. A read then returns all ones and a write is dropped. Only one request is outstanding at a time.

Top module: `cfg1_decoder`

## Requirements
- R1: After reset the address register holds zero, so a dword read of port 0xCF8 returns 0x00000000. `cfg_req` and `io_done` are low while reset is applied.
- R2: With size code 2'b10 (dword), a write to port 0xCF8 loads the address register. Size codes are 2'b00 byte, 2'b01 word and 2'b10 dword. A dword read of 0xCF8 returns bit 31 enable, bits 27:24 extended register, bits 23:16 bus, bits 15:8 device/function and bits 7:2 dword index, with bits 30:28 and 1:0 as zero. Writing 0x80000000 reads back as exactly 0x80000000.
- R3: Some accesses touch neither a dword at 0xCF8 nor the window 0xCFC–0xCFF. Examples are a byte or word at 0xCF8–0xCFB, or any other port. These complete one cycle after the strobe, change nothing, and return 0xFFFFFFFF on a read.
- R4: While the enable bit is clear, a data-window access raises no `cfg_req`. It completes one cycle after the strobe and a read returns 0xFFFFFFFF.
- R5: While the enable bit is set, a data-window access raises `cfg_req` in the cycle after the strobe. `cfg_bus` is taken from address bits 23:16 and `cfg_devfn` from bits 15:8. `cfg_dword` is {bits 27:24, bits 7:2}.
- R6: Lane k carries data bits 8k+7:8k. A byte enables only lane port[1:0]. A word enables lanes 1:0 when port[1] is 0 and lanes 3:2 when it is 1. A dword enables all four lanes at any window port.
- R7: `cfg_we` and `cfg_wdata` carry the I/O write flag and data unchanged. `cfg_ack` counts only while `cfg_req` is high. After an acknowledge, `cfg_req` drops and `io_done` pulses in the next cycle with `io_rdata` equal to the `cfg_rdata` word sampled with the acknowledge.
- R8: `cfg_req` stays high for at most TIMEOUT cycles. An acknowledge in the TIMEOUT-th cycle is still accepted. Without one, the request ends, `io_done` pulses and a read returns 0xFFFFFFFF.
- R9: All request fields stay stable while `cfg_req` is high. An `io_req` strobe during an outstanding request is ignored and does not alter the address register.
- R10: `io_done` is a single-cycle pulse, one per accepted access.

Ports follow the order of the port list:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| io_req | input | 1 | One-cycle access strobe |
| io_we | input | 1 | 1 = write, 0 = read |
| io_port | input | 16 | I/O port address |
| io_size | input | 2 | 00 byte, 01 word, 10 dword |
| io_wdata | input | 32 | Write data, lane aligned |
| io_done | output | 1 | Completion pulse |
| io_rdata | output | 32 | Read data, valid with io_done |
| cfg_req | output | 1 | Downstream request, held until acknowledge or timeout |
| cfg_we | output | 1 | Downstream write flag |
| cfg_bus | output | 8 | Target bus number |
| cfg_devfn | output | 8 | Target device/function |
| cfg_dword | output | 10 | Dword index within 4 KB space |
| cfg_be | output | 4 | Lane byte enables |
| cfg_wdata | output | 32 | Downstream write data |
| cfg_ack | input | 1 | Target acknowledge |
| cfg_rdata | input | 32 | Target read data, valid with cfg_ack |

## Verification
Several behaviours are checked on every cycle by assertions. These are the stability of request fields while `cfg_req` is high, and the bound of TIMEOUT cycles on a request. They also cover the legal byte-enable shapes, the one-cycle width of `io_done`, completion one cycle after an acknowledge, and the rule that a request only begins while the enable bit is set. The scenarios must show the data values themselves: register readback with masked bits, immunity to partial writes at the address port, exact lane selection per port and size, field mapping onto the request, and all-ones data after a timeout. They must also show acceptance of an acknowledge in the last allowed cycle and the dropping of a strobe issued while busy.

// File: rtl/cfg1_pkg.sv
package cfg1_pkg;

  localparam int DATA_W  = 32;
  localparam int LANES   = DATA_W / 8;
  localparam int BUS_W   = 8;
  localparam int DEVFN_W = 8;
  localparam int EXT_W   = 4;
  localparam int IDX_W   = 6;
  localparam int DWORD_W = EXT_W + IDX_W;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_WORD  = 2'b01,
    SZ_DWORD = 2'b10
  } io_size_e;

  typedef struct packed {
    logic               en;
    logic [EXT_W-1:0]   ext;
    logic [BUS_W-1:0]   bus;
    logic [DEVFN_W-1:0] devfn;
    logic [IDX_W-1:0]   idx;
  } sel_reg_t;

  typedef enum logic {
    XS_IDLE = 1'b0,
    XS_WAIT = 1'b1
  } xfer_state_e;

endpackage

// File: rtl/cfg1_sel_reg.sv
module cfg1_sel_reg
  import cfg1_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ld_en,
  input  sel_reg_t            ld_val,
  output sel_reg_t            sel_q,
  output logic [DATA_W-1:0]   sel_rdback
);

  sel_reg_t sel_d;

  always_comb begin
    sel_d = sel_q;
    if (ld_en) sel_d = ld_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= sel_d;
  end

  // Unimplemented bits 30:28 and 1:0 read as zero.
  assign sel_rdback = {sel_q.en, 3'b000, sel_q.ext, sel_q.bus,
                       sel_q.devfn, sel_q.idx, 2'b00};

endmodule

// File: rtl/cfg1_lane_decode.sv
module cfg1_lane_decode
  import cfg1_pkg::*;
#(
  parameter int NLANE = LANES,
  localparam int OFF_W = $clog2(NLANE)
) (
  input  logic [OFF_W-1:0] offset,
  input  logic [1:0]       size,
  output logic [NLANE-1:0] lane_en
);

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    always_comb begin
      case (size)
        SZ_BYTE: lane_en[i] = (offset == OFF_W'(i));
        SZ_WORD: lane_en[i] = ((offset >> 1) == OFF_W'(i >> 1));
        default: lane_en[i] = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/cfg1_xfer_ctrl.sv
module cfg1_xfer_ctrl
  import cfg1_pkg::*;
#(
  parameter int TIMEOUT = 16,
  localparam int TMR_W = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_fwd,
  input  logic              start_local,
  input  logic [DATA_W-1:0] local_rdata,
  input  logic              in_we,
  input  logic [LANES-1:0]  in_be,
  input  logic [DATA_W-1:0] in_wdata,
  input  logic              cfg_ack,
  input  logic [DATA_W-1:0] cfg_rdata,
  output logic              busy,
  output logic              cfg_req,
  output logic              cfg_we,
  output logic [LANES-1:0]  cfg_be,
  output logic [DATA_W-1:0] cfg_wdata,
  output logic              io_done,
  output logic [DATA_W-1:0] io_rdata
);

  xfer_state_e       state_q, state_d;
  logic [TMR_W-1:0]  tmr_q, tmr_d;
  logic              done_q, done_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              lat_en, rdata_en;
  logic              we_q;
  logic [LANES-1:0]  be_q;
  logic [DATA_W-1:0] wdata_q;

  always_comb begin
    state_d  = state_q;
    tmr_d    = tmr_q;
    done_d   = 1'b0;
    rdata_d  = rdata_q;
    rdata_en = 1'b0;
    lat_en   = 1'b0;
    case (state_q)
      XS_IDLE: begin
        if (start_fwd) begin
          state_d = XS_WAIT;
          tmr_d   = '0;
          lat_en  = 1'b1;
        end else if (start_local) begin
          done_d   = 1'b1;
          rdata_d  = local_rdata;
          rdata_en = 1'b1;
        end
      end
      XS_WAIT: begin
        if (cfg_ack) begin
          state_d  = XS_IDLE;
          done_d   = 1'b1;
          rdata_d  = cfg_rdata;
          rdata_en = 1'b1;
        end else if (tmr_q == TMR_W'(TIMEOUT - 1)) begin
          state_d  = XS_IDLE;
          done_d   = 1'b1;
          rdata_d  = '1;
          rdata_en = 1'b1;
        end else begin
          tmr_d = tmr_q + 1'b1;
        end
      end
      default: state_d = XS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= XS_IDLE;
      tmr_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      tmr_q   <= tmr_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata_q <= '0;
    else if (rdata_en) rdata_q <= rdata_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q    <= 1'b0;
      be_q    <= '0;
      wdata_q <= '0;
    end else if (lat_en) begin
      we_q    <= in_we;
      be_q    <= in_be;
      wdata_q <= in_wdata;
    end
  end

  assign busy      = (state_q == XS_WAIT);
  assign cfg_req   = busy;
  assign cfg_we    = we_q;
  assign cfg_be    = be_q;
  assign cfg_wdata = wdata_q;
  assign io_done   = done_q;
  assign io_rdata  = rdata_q;

endmodule

// File: rtl/cfg1_decoder.sv
module cfg1_decoder
  import cfg1_pkg::*;
#(
  parameter int                PORT_W    = 16,
  parameter logic [PORT_W-1:0] ADDR_PORT = 16'hCF8,
  parameter logic [PORT_W-1:0] DATA_PORT = 16'hCFC,
  parameter int                TIMEOUT   = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                io_req,
  input  logic                io_we,
  input  logic [PORT_W-1:0]   io_port,
  input  logic [1:0]          io_size,
  input  logic [DATA_W-1:0]   io_wdata,
  output logic                io_done,
  output logic [DATA_W-1:0]   io_rdata,
  output logic                cfg_req,
  output logic                cfg_we,
  output logic [BUS_W-1:0]    cfg_bus,
  output logic [DEVFN_W-1:0]  cfg_devfn,
  output logic [DWORD_W-1:0]  cfg_dword,
  output logic [LANES-1:0]    cfg_be,
  output logic [DATA_W-1:0]   cfg_wdata,
  input  logic                cfg_ack,
  input  logic [DATA_W-1:0]   cfg_rdata
);

  localparam int OFF_W = $clog2(LANES);
  localparam logic [PORT_W-OFF_W-1:0] DATA_BLK = DATA_PORT[PORT_W-1:OFF_W];

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  sel_reg_t          sel_q;
  sel_reg_t          sel_ld_val;
  logic [DATA_W-1:0] sel_rdback;
  logic              addr_en;
  logic              busy;
  logic              accept, addr_hit, win_hit, fwd_hit;
  logic              sel_ld, start_fwd, start_local;
  logic [DATA_W-1:0] local_rdata;
  logic [LANES-1:0]  lane_en;

  assign addr_hit = (io_port == ADDR_PORT) && (io_size == SZ_DWORD);
  assign win_hit  = (io_port[PORT_W-1:OFF_W] == DATA_BLK);
  assign addr_en  = sel_q.en;
  assign fwd_hit  = win_hit && addr_en;
  assign accept   = io_req && !busy;

  assign sel_ld      = accept && addr_hit && io_we;
  assign start_fwd   = accept && fwd_hit;
  assign start_local = accept && !fwd_hit;
  assign local_rdata = (addr_hit && !io_we) ? sel_rdback : '1;

  assign sel_ld_val = '{en:    io_wdata[31],
                        ext:   io_wdata[27:24],
                        bus:   io_wdata[23:16],
                        devfn: io_wdata[15:8],
                        idx:   io_wdata[7:2]};

  cfg1_sel_reg u_sel (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .ld_en      (sel_ld),
    .ld_val     (sel_ld_val),
    .sel_q      (sel_q),
    .sel_rdback (sel_rdback)
  );

  cfg1_lane_decode #(.NLANE(LANES)) u_lane (
    .offset  (io_port[OFF_W-1:0]),
    .size    (io_size),
    .lane_en (lane_en)
  );

  cfg1_xfer_ctrl #(.TIMEOUT(TIMEOUT)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .start_fwd   (start_fwd),
    .start_local (start_local),
    .local_rdata (local_rdata),
    .in_we       (io_we),
    .in_be       (lane_en),
    .in_wdata    (io_wdata),
    .cfg_ack     (cfg_ack),
    .cfg_rdata   (cfg_rdata),
    .busy        (busy),
    .cfg_req     (cfg_req),
    .cfg_we      (cfg_we),
    .cfg_be      (cfg_be),
    .cfg_wdata   (cfg_wdata),
    .io_done     (io_done),
    .io_rdata    (io_rdata)
  );

  // Selector fields cannot change while busy: strobes are refused then.
  assign cfg_bus   = sel_q.bus;
  assign cfg_devfn = sel_q.devfn;
  assign cfg_dword = {sel_q.ext, sel_q.idx};

endmodule

// File: rtl/cfg1_decoder_chk.sv
module cfg1_decoder_chk #(
  parameter int TIMEOUT = 16,
  localparam int CNT_W = $clog2(TIMEOUT + 1) + 1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        io_done,
  input logic        cfg_req,
  input logic        cfg_ack,
  input logic        cfg_we,
  input logic [7:0]  cfg_bus,
  input logic [7:0]  cfg_devfn,
  input logic [9:0]  cfg_dword,
  input logic [3:0]  cfg_be,
  input logic [31:0] cfg_wdata,
  input logic        addr_en
);

  logic [CNT_W-1:0] req_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       req_cnt <= '0;
    else if (cfg_req) req_cnt <= req_cnt + 1'b1;
    else              req_cnt <= '0;
  end

  p_fields_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && $past(cfg_req)) |->
      $stable({cfg_we, cfg_bus, cfg_devfn, cfg_dword, cfg_be, cfg_wdata}));

  p_ack_completes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && cfg_ack) |=> (io_done && !cfg_req));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    io_done |=> !io_done);

  p_be_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> ($countones(cfg_be) == 1 || cfg_be == 4'h3 ||
                 cfg_be == 4'hC || cfg_be == 4'hF));

  p_timeout_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> (req_cnt < CNT_W'(TIMEOUT)));

  p_fwd_needs_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_req) |-> $past(addr_en));

endmodule

bind cfg1_decoder cfg1_decoder_chk #(.TIMEOUT(TIMEOUT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_int),
  .io_done   (io_done),
  .cfg_req   (cfg_req),
  .cfg_ack   (cfg_ack),
  .cfg_we    (cfg_we),
  .cfg_bus   (cfg_bus),
  .cfg_devfn (cfg_devfn),
  .cfg_dword (cfg_dword),
  .cfg_be    (cfg_be),
  .cfg_wdata (cfg_wdata),
  .addr_en   (addr_en)
);

// File: tb/test_cfg1_decoder.sv
module test_cfg1_decoder;

  localparam int TMO = 16;

  typedef struct packed {
    logic        we;
    logic [15:0] port;
    logic [1:0]  size;
    logic [31:0] wdata;
    logic [7:0]  delay;   // 8'hFF: target never acknowledges
    logic [31:0] rsp;
    logic        fwd;
    logic [3:0]  be;
    logic [31:0] rdata;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 16'hCF8, 2'd2, 32'hF5ABC8E7, 8'd0,   32'h0,        1'b0, 4'h0, 32'h0},
    '{1'b0, 16'hCF8, 2'd2, 32'h0,        8'd0,   32'h0,        1'b0, 4'h0, 32'h85ABC8E4},
    '{1'b1, 16'hCFB, 2'd0, 32'h01000000, 8'd0,   32'h0,        1'b0, 4'h0, 32'h0},
    '{1'b0, 16'hCF8, 2'd2, 32'h0,        8'd0,   32'h0,        1'b0, 4'h0, 32'h85ABC8E4},
    '{1'b0, 16'hCFC, 2'd2, 32'h0,        8'd2,   32'h12345678, 1'b1, 4'hF, 32'h12345678},
    '{1'b0, 16'hCFE, 2'd0, 32'h0,        8'd0,   32'hCAFEF00D, 1'b1, 4'h4, 32'hCAFEF00D},
    '{1'b1, 16'hCFD, 2'd1, 32'h0000BEEF, 8'd1,   32'h0,        1'b1, 4'h3, 32'h0},
    '{1'b1, 16'hCFF, 2'd0, 32'h5A000000, 8'd3,   32'h0,        1'b1, 4'h8, 32'h0},
    '{1'b0, 16'hCFE, 2'd1, 32'h0,        8'd0,   32'hA5A5A5A5, 1'b1, 4'hC, 32'hA5A5A5A5},
    '{1'b0, 16'hCFD, 2'd2, 32'h0,        8'd15,  32'h0BADBEEF, 1'b1, 4'hF, 32'h0BADBEEF},
    '{1'b0, 16'hCFC, 2'd2, 32'h0,        8'hFF,  32'h0,        1'b1, 4'hF, 32'hFFFFFFFF},
    '{1'b1, 16'hCF9, 2'd1, 32'h00123400, 8'd0,   32'h0,        1'b0, 4'h0, 32'h0},
    '{1'b0, 16'hCF8, 2'd2, 32'h0,        8'd0,   32'h0,        1'b0, 4'h0, 32'h85ABC8E4},
    '{1'b1, 16'hCF8, 2'd2, 32'h0,        8'd0,   32'h0,        1'b0, 4'h0, 32'h0},
    '{1'b0, 16'hCFC, 2'd2, 32'h0,        8'd0,   32'h11111111, 1'b0, 4'h0, 32'hFFFFFFFF},
    '{1'b1, 16'hCFD, 2'd0, 32'h0000AA00, 8'd0,   32'h0,        1'b0, 4'h0, 32'h0},
    '{1'b0, 16'h0080, 2'd2, 32'h0,       8'd0,   32'h0,        1'b0, 4'h0, 32'hFFFFFFFF}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_req = 1'b0;
  logic        io_we = 1'b0;
  logic [15:0] io_port = 16'h0;
  logic [1:0]  io_size = 2'd0;
  logic [31:0] io_wdata = 32'h0;
  logic        io_done;
  logic [31:0] io_rdata;
  logic        cfg_req, cfg_we;
  logic [7:0]  cfg_bus, cfg_devfn;
  logic [9:0]  cfg_dword;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata;
  logic        cfg_ack = 1'b0;
  logic [31:0] cfg_rdata = 32'h0;

  always #5 clk = ~clk;

  cfg1_decoder #(.TIMEOUT(TMO)) i_cfg1_decoder (
    .clk(clk), .rst_n(rst_n),
    .io_req(io_req), .io_we(io_we), .io_port(io_port), .io_size(io_size),
    .io_wdata(io_wdata), .io_done(io_done), .io_rdata(io_rdata),
    .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_bus(cfg_bus),
    .cfg_devfn(cfg_devfn), .cfg_dword(cfg_dword), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_ack(cfg_ack), .cfg_rdata(cfg_rdata)
  );

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  // Observations of the latest access
  logic        seen, stable_ok, hung, done_after, c_we;
  logic [3:0]  c_be;
  logic [7:0]  c_bus, c_devfn;
  logic [9:0]  c_dword;
  logic [31:0] c_wdata, got_rdata;
  int          lat, req_cyc;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_fail++;
      $display("FAIL watchdog R10: actual no completion expected finish");
      summary();
      $finish;
    end
  end

  // Called at a falling edge; drives a one-cycle strobe and plays the target.
  task automatic access(input logic we, input logic [15:0] port, input logic [1:0] sz,
                        input logic [31:0] wd, input logic [7:0] dly, input logic [31:0] rsp);
    io_req = 1'b1; io_we = we; io_port = port; io_size = sz; io_wdata = wd;
    @(negedge clk);
    io_req = 1'b0;
    seen = 1'b0; stable_ok = 1'b1; hung = 1'b1; lat = 0; req_cyc = 0;
    for (int n = 0; n < 100; n++) begin
      cfg_ack = 1'b0;
      if (io_done) begin
        got_rdata = io_rdata;
        hung = 1'b0;
        break;
      end
      if (cfg_req) begin
        if (!seen) begin
          seen = 1'b1;
          c_we = cfg_we; c_be = cfg_be; c_bus = cfg_bus;
          c_devfn = cfg_devfn; c_dword = cfg_dword; c_wdata = cfg_wdata;
        end else if ({cfg_we, cfg_be, cfg_bus, cfg_devfn, cfg_dword, cfg_wdata} !==
                     {c_we, c_be, c_bus, c_devfn, c_dword, c_wdata}) begin
          stable_ok = 1'b0;
        end
        if (dly != 8'hFF && req_cyc == int'(dly)) begin
          cfg_ack = 1'b1;
          cfg_rdata = rsp;
        end
        req_cyc++;
      end
      lat++;
      @(negedge clk);
    end
    cfg_ack = 1'b0;
    @(negedge clk);
    done_after = io_done;
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 io_done in reset", {31'b0, io_done}, 32'h0);
    chk("R1 cfg_req in reset", {31'b0, cfg_req}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    access(1'b0, 16'hCF8, 2'd2, 32'h0, 8'd0, 32'h0);
    chk("R1 address register after reset", got_rdata, 32'h0);

    // R2: enable-only round trip
    access(1'b1, 16'hCF8, 2'd2, 32'h80000000, 8'd0, 32'h0);
    access(1'b0, 16'hCF8, 2'd2, 32'h0, 8'd0, 32'h0);
    chk("R2 enable-only readback", got_rdata, 32'h80000000);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      string rtag;
      access(VECS[v].we, VECS[v].port, VECS[v].size, VECS[v].wdata,
             VECS[v].delay, VECS[v].rsp);
      chk("R10 completion reached", {31'b0, hung}, 32'h0);
      chk("R10 done is one cycle", {31'b0, done_after}, 32'h0);
      chk("R4 forward decision", {31'b0, seen}, {31'b0, VECS[v].fwd});
      if (VECS[v].fwd) begin
        chk("R6 byte enables", {28'b0, c_be}, {28'b0, VECS[v].be});
        chk("R5 bus field", {24'b0, c_bus}, 32'hAB);
        chk("R5 devfn field", {24'b0, c_devfn}, 32'hC8);
        chk("R5 dword index", {22'b0, c_dword}, 32'h179);
        chk("R7 write flag", {31'b0, c_we}, {31'b0, VECS[v].we});
        chk("R9 fields stable", {31'b0, stable_ok}, 32'h1);
        if (VECS[v].we) chk("R7 write data", c_wdata, VECS[v].wdata);
        if (VECS[v].delay == 8'hFF) chk("R8 request length", req_cyc, TMO);
      end else begin
        chk("R3 local latency", lat, 0);
      end
      if (!VECS[v].we) begin
        if (VECS[v].fwd && VECS[v].delay == 8'hFF) rtag = "R8 timeout data";
        else if (VECS[v].fwd)                      rtag = "R7 read data";
        else if (VECS[v].port == 16'hCF8)          rtag = "R2 readback";
        else                                       rtag = "R3 unclaimed or disabled data";
        chk(rtag, got_rdata, VECS[v].rdata);
      end
    end

    // R9: strobe while a request is outstanding is ignored
    access(1'b1, 16'hCF8, 2'd2, 32'hF5ABC8E7, 8'd0, 32'h0);
    io_req = 1'b1; io_we = 1'b0; io_port = 16'hCFC; io_size = 2'd2;
    @(negedge clk);
    io_req = 1'b0;
    chk("R5 request raised", {31'b0, cfg_req}, 32'h1);
    @(negedge clk);
    io_req = 1'b1; io_we = 1'b1; io_port = 16'hCF8; io_size = 2'd2; io_wdata = 32'h0;
    @(negedge clk);
    io_req = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 request still held", {31'b0, cfg_req}, 32'h1);
    cfg_ack = 1'b1; cfg_rdata = 32'h600DF00D;
    @(negedge clk);
    cfg_ack = 1'b0;
    chk("R7 done after ack", {31'b0, io_done}, 32'h1);
    chk("R7 read data after ack", io_rdata, 32'h600DF00D);
    @(negedge clk);
    chk("R9 no extra completion", {31'b0, io_done}, 32'h0);
    access(1'b0, 16'hCF8, 2'd2, 32'h0, 8'd0, 32'h0);
    chk("R9 ignored strobe left register", got_rdata, 32'h85ABC8E4);

    summary();
    $finish;
  end

endmodule